// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between an on-chip request port and an external 128K x 8 asynchronous static RAM. Each accepted request, a read or a write of one byte, becomes a sequence of chip-select, output-enable and write-enable levels. Clock-cycle counters hold each level long enough for the RAM's access, pulse-width, data-setup and bus-release times. The RAM's two chip selects have opposite polarity (one active low, one active high) and are always switched together. The data bus is modelled as a separate output, input and driver-enable, so that a pad ring can form the bidirectional pin.

The request side is valid/ready. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its address, data and direction are latched on that edge. While an access is in progress `req_ready` stays low, and anything on the request inputs is ignored; this is the whole back-pressure rule. There is no response back-pressure: `rsp_done` is a single-cycle pulse, and the response side must take it in that cycle. Read data stays on `rsp_rdata` until the next read completes.

Timing is set by a clock period parameter and a speed-grade selector. The slow grade uses 45 ns cycle/access, 35 ns write pulse, 25 ns data setup and 15 ns bus release. The fast grade uses 35, 25, 20 and 10 ns. Each time is rounded up to whole clocks. At the default 10 ns clock and slow grade this gives access = 5, release = 2, setup = 3 and write pulse = max(4, 2+3) = 5 cycles.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After synchronous reset, and whenever idle, the RAM is in standby: `ram_ce1_n`=1, `ram_ce2`=0, `ram_oe_n`=1, `ram_we_n`=1, `ram_dq_oe`=0, with `req_ready`=1.
- R2: `req_ready` is high only when idle; a request is accepted on an edge with `req_valid` and `req_ready` both high.
- R3: A read holds the chip selected with OE low and WE high for ACC cycles (5 by default), with the latched address on `ram_addr`. `rsp_done` appears on the ACC+1-th cycle after acceptance.
- R4: Read data is sampled from `ram_dq_in` on the edge that ends the last access cycle. `rsp_done` pulses for exactly one cycle with that byte on `rsp_rdata`.
- R5: A write has one setup cycle (selected, WE high), then WE low for PULSE cycles (7 cycles from acceptance to done by default), then a recovery cycle with WE high and the chip still selected. OE stays high throughout, and the address is stable while WE is low.
- R6: Data drivers turn on only after WE has been low for REL cycles (2 by default). This leaves exactly PULSE-REL cycles (3 by default) of driven, stable data before WE rises. Drivers stay on through the recovery cycle and turn off only after WE is high.
- R7: A write completes with a one-cycle `rsp_done` in the recovery cycle and leaves `rsp_rdata` unchanged.
- R8: The drivers are never on while OE is low. After a read, the chip stays deselected with OE high for 1+REL cycles after `rsp_done` before `req_ready` returns. After a write it stays deselected for 1 cycle.
- R9: While an access is in progress, changes on `req_valid`, `req_write`, `req_addr` and `req_wdata` have no effect on `ram_addr`, on the data written, or on `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| ram_addr | output | 17 | RAM address |
| ram_ce1_n | output | 1 | Active-low chip select |
| ram_ce2 | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq_out | output | 8 | Data to RAM |
| ram_dq_oe | output | 1 | Data driver enable |
| ram_dq_in | input | 8 | Data from RAM |

## Verification
A RAM model inside the bench answers reads with real data only once the access has been held for the full access time. Before that it returns a poison byte, so a capture that comes even one cycle early is caught. The same model commits a write only if WE rises while the chip is selected and the drivers are still on, and it measures the WE pulse and the driven-data window. Random mixes of reads and writes over a small address pool produce read-after-write, write-after-write and read-of-never-written cases. These tell lost, misplaced and stale writes apart. Directed accesses at address 0 and at the top address, back-to-back reads and writes, and request inputs that toggle during busy periods separate sequencing errors from handshake errors.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctl_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic drv;
  } strobe_t;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (cnt != '1)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int REL_CYC = 2
) (
  input  ctl_state_e       state,
  input  logic [CNT_W-1:0] cnt,
  output strobe_t          strb
);
  always_comb begin
    strb = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    unique case (state)
      ST_RD_ACCESS: begin
        strb.ce1_n = 1'b0;
        strb.ce2   = 1'b1;
        strb.oe_n  = 1'b0;
      end
      ST_WR_SETUP: begin
        strb.ce1_n = 1'b0;
        strb.ce2   = 1'b1;
      end
      ST_WR_PULSE: begin
        strb.ce1_n = 1'b0;
        strb.ce2   = 1'b1;
        strb.we_n  = 1'b0;
        strb.drv   = (cnt >= CNT_W'(REL_CYC));
      end
      ST_WR_RECOVER: begin
        strb.ce1_n = 1'b0;
        strb.ce2   = 1'b1;
        strb.drv   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/read_capture.sv
module read_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else if (load)
      dout <= din;
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter bit FAST_GRADE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce1_n,
  output logic              ram_ce2,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  // speed grade timing in ns
  localparam int T_CYC_NS = FAST_GRADE ? 35 : 45;
  localparam int T_PWE_NS = FAST_GRADE ? 25 : 35;
  localparam int T_SD_NS  = FAST_GRADE ? 20 : 25;
  localparam int T_REL_NS = FAST_GRADE ? 10 : 15;

  // converted to clock cycles
  localparam int ACC_CYC   = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int PWE_CYC   = ns_to_cyc(T_PWE_NS, CLK_NS);
  localparam int SD_CYC    = ns_to_cyc(T_SD_NS, CLK_NS);
  localparam int REL_CYC   = ns_to_cyc(T_REL_NS, CLK_NS);
  localparam int PULSE_CYC = max2(PWE_CYC, REL_CYC + SD_CYC);
  localparam int REC_CYC   = max2(1, ACC_CYC - 1 - PULSE_CYC);
  localparam int MAX_CYC   = max2(max2(ACC_CYC, PULSE_CYC), max2(REL_CYC, REC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] ACC_LAST   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LAST   = CNT_W'(REL_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);

  ctl_state_e        state, state_nxt;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  strobe_t           strb;
  logic              accept;
  logic              cap_load;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign cap_load = (state == ST_RD_ACCESS) && (cnt == ACC_LAST);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:       if (req_valid) state_nxt = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (cnt == ACC_LAST) state_nxt = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_nxt = ST_TURNAROUND;
      ST_TURNAROUND: if (cnt == REL_LAST) state_nxt = ST_IDLE;
      ST_WR_SETUP:   state_nxt = ST_WR_PULSE;
      ST_WR_PULSE:   if (cnt == PULSE_LAST) state_nxt = ST_WR_RECOVER;
      ST_WR_RECOVER: if (cnt == REC_LAST) state_nxt = ST_IDLE;
      default:       state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state <= state_nxt;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state_nxt != state),
    .cnt (cnt)
  );

  strobe_decode #(.CNT_W(CNT_W), .REL_CYC(REL_CYC)) u_dec (
    .state (state),
    .cnt   (cnt),
    .strb  (strb)
  );

  read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .load (cap_load),
    .din  (ram_dq_in),
    .dout (rsp_rdata)
  );

  assign req_ready  = (state == ST_IDLE);
  assign rsp_done   = (state == ST_RD_CAPTURE) || ((state == ST_WR_RECOVER) && (cnt == '0));
  assign ram_addr   = addr_q;
  assign ram_dq_out = wdata_q;
  assign ram_ce1_n  = strb.ce1_n;
  assign ram_ce2    = strb.ce2;
  assign ram_oe_n   = strb.oe_n;
  assign ram_we_n   = strb.we_n;
  assign ram_dq_oe  = strb.drv;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce1_n,
  input logic              ram_ce2,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              ram_dq_oe
);
  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_ce1_n && !ram_ce2 && ram_oe_n && ram_we_n && !ram_dq_oe));

  // R2
  busy_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !req_ready);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R5
  we_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (ram_oe_n && !ram_ce1_n && ram_ce2));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> $stable(ram_addr));

  // R6
  drv_after_we_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_dq_oe) |-> (!ram_we_n && $past(!ram_we_n)));

  // R6
  drv_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_dq_oe) |-> $past(ram_we_n));

  // R8
  drv_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (ram_oe_n && !ram_ce1_n && ram_ce2));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .ram_addr  (ram_addr),
  .ram_ce1_n (ram_ce1_n),
  .ram_ce2   (ram_ce2),
  .ram_oe_n  (ram_oe_n),
  .ram_we_n  (ram_we_n),
  .ram_dq_oe (ram_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;
  localparam int CLK_NS = 10;
  localparam int EXP_ACC   = (45 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_REL   = (15 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_SD    = (25 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_PWE   = (35 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_PULSE = (EXP_PWE > EXP_REL + EXP_SD) ? EXP_PWE : EXP_REL + EXP_SD;
  localparam int EXP_RD_LAT = EXP_ACC + 1;
  localparam int EXP_WR_LAT = EXP_PULSE + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done;
  logic [7:0] rsp_rdata;
  logic [16:0] ram_addr;
  logic ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0] ram_dq_out;
  logic [7:0] ram_dq_in = 8'hEE;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_strobe_ctrl #(.CLK_NS(CLK_NS)) i_sram_strobe_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input logic [16:0] a);
    return a[7:0] ^ {1'b0, a[16:10]} ^ 8'h5A;
  endfunction

  // RAM model, evaluated once per cycle at the falling edge
  logic [7:0] model_mem [int];
  logic [7:0] ref_mem   [int];
  int rd_age = 0, wl = 0, drv = 0;
  bit we_prev = 1'b1, drv_unstable = 1'b0;
  logic [7:0] dq_prev = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ram_ce1_n && ram_ce2 && !ram_oe_n && ram_we_n) begin
        rd_age++;
        if (rd_age >= EXP_ACC)
          ram_dq_in = model_mem.exists(int'(ram_addr)) ? model_mem[int'(ram_addr)] : init_byte(ram_addr);
        else
          ram_dq_in = 8'hEE;
      end else begin
        rd_age = 0;
        ram_dq_in = 8'hEE;
      end
      if (!ram_we_n) begin
        wl++;
        if (ram_dq_oe) begin
          if (drv > 0 && ram_dq_out != dq_prev) drv_unstable = 1'b1;
          drv++;
          dq_prev = ram_dq_out;
        end
      end else if (!we_prev) begin
        // R5 WE low length, R6 driven window before WE rises and hold after it
        check(wl == EXP_PULSE, "R5 we pulse", wl, EXP_PULSE);
        check(drv == EXP_PULSE - EXP_REL && !drv_unstable, "R6 drive window", drv, EXP_PULSE - EXP_REL);
        check(ram_dq_oe && !ram_ce1_n && ram_ce2, "R6 hold after WE", ram_dq_oe, 1);
        if (ram_dq_oe && !ram_ce1_n && ram_ce2)
          model_mem[int'(ram_addr)] = ram_dq_out;
        wl = 0;
        drv = 0;
        drv_unstable = 1'b0;
      end
      we_prev = ram_we_n;
    end
  end

  function automatic logic [7:0] ref_rd(input logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_byte(a);
  endfunction

  task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int lat;
    bit bad;
    logic [7:0] rd_before;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    rd_before = rsp_rdata;
    @(negedge clk);
    lat = 1;
    bad = 1'b0;
    // R9: noise on the request inputs while busy
    req_valid = 1'($urandom_range(0, 1));
    req_write = 1'($urandom_range(0, 1));
    req_addr  = 17'($urandom);
    req_wdata = 8'($urandom);
    while (!rsp_done && lat < 40) begin
      if (req_ready) bad = 1'b1;
      if (!ram_ce1_n && ram_addr != a) bad = 1'b1;
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    check(!bad, "R2 R9 busy isolation", bad, 0);
    if (wr) begin
      check(lat == EXP_WR_LAT, "R5 write latency", lat, EXP_WR_LAT);
      check(rsp_rdata == rd_before, "R7 rdata kept", rsp_rdata, rd_before);
      ref_mem[int'(a)] = d;
    end else begin
      check(lat == EXP_RD_LAT, "R3 read latency", lat, EXP_RD_LAT);
      check(rsp_rdata == ref_rd(a), "R4 read data", rsp_rdata, ref_rd(a));
    end
    lat = 0;
    bad = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (!req_ready && (!ram_oe_n || !ram_ce1_n || rsp_done)) bad = 1'b1;
    end while (!req_ready && lat < 40);
    check(!bad && lat == (wr ? 1 : EXP_REL + 1), "R8 gap after access", lat, wr ? 1 : EXP_REL + 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 standby after reset
    check(req_ready && ram_ce1_n && !ram_ce2 && ram_oe_n && ram_we_n && !ram_dq_oe,
          "R1 reset standby", {req_ready, ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe}, 6'b110110);
    check(!rsp_done, "R1 no done after reset", rsp_done, 0);

    // directed corners
    run_op(1'b0, 17'h00000, 8'h00);      // never written
    run_op(1'b1, 17'h00000, 8'hA5);
    run_op(1'b0, 17'h00000, 8'h00);
    run_op(1'b1, 17'h1FFFF, 8'h3C);
    run_op(1'b1, 17'h1FFFF, 8'hC3);      // overwrite, last wins
    run_op(1'b0, 17'h1FFFF, 8'h00);
    run_op(1'b0, 17'h1FFFF, 8'h00);      // back-to-back reads
    run_op(1'b1, 17'h00001, 8'hFF);
    run_op(1'b1, 17'h00002, 8'h00);
    run_op(1'b0, 17'h00001, 8'h00);
    run_op(1'b0, 17'h00002, 8'h00);

    // random mix over a small pool
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      a = 17'(($urandom_range(0, 3) << 15) | $urandom_range(0, 15));
      run_op(1'($urandom_range(0, 1)), a, 8'($urandom));
    end
    finish_run();
  end
endmodule